// File: doc/BRIEF.md
# Performance Counter Enable Controller

This block keeps the run/stop state for a small performance monitor that has one cycle counter and three event counters. Each counter has a single enable bit, and all of these bits sit in one stored vector. Software sees that vector through two register windows. Writing ones to the "arm" window starts the selected counters. Writing ones to the "disarm" window stops them. Zeros written to either window change nothing. Both windows read back the same stored vector.

A master-run bit in a control register gates every counter at once and leaves the stored enables as they are. A counter advances by one on a clock edge only when the master-run bit, its own enable and its event input are all 1. The cycle counter treats its event input as always 1.

Register access uses a plain strobe bus: one write strobe, one read strobe, a word index, write data and combinational read data. An access flagged as user-level is refused unless a user-access bit is set. A refused access reads as zero, changes nothing and raises an error pulse.

Top module: `perf_enable_ctrl`

## Requirements
- R1: The enable vector maps the cycle counter to bit 31 and event counters 0, 1 and 2 to bits 0, 1 and 2. Bits 3 to 30 always read 0, and writes to them are dropped.
- R2: A permitted write to the disarm window (index 2) clears each enable whose data bit is 1 and leaves each enable whose data bit is 0 unchanged.
- R3: A read of the arm window (index 1) and a read of the disarm window (index 2) both return the current enable vector, with 1 meaning enabled.
- R4: After reset, the enable vector, the master-run bit, the user-access bit and every counter are 0.
- R5: A permitted write to the arm window sets each enable whose data bit is 1 and never clears an enable. Writing 0 has no effect.
- R6: Bit 0 of the control register (index 0) is the master-run bit. While it is 0, no counter changes, including the cycle counter.
- R7: While the master-run bit is 0, the stored enables keep their values and can still be changed through both windows.
- R8: On each clock edge where the master-run bit is 1 and its own enable is 1, a counter adds 1 when its event input is 1. The event input for event counter n is bit n of the event bus, and the cycle counter's event is a constant 1. Counters are CNT_W bits wide and wrap to 0.
- R9: A user-level access while the user-access bit (index 3, bit 0) is 0 reads as 0 and changes no state. Its error output is 1 in the cycle after the access.
- R10: The user-access bit can be written only by a non-user access. A user-level write to index 3 is refused as in R9, even when user access is enabled.
- R11: The counters can be read at indices 4 (cycle), 5, 6 and 7 (events 0 to 2), zero-extended to 32 bits. Writes to these indices change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_user | input | 1 | Access is made at user privilege |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle the read strobe is high |
| bus_err | output | 1 | One-cycle pulse after a refused access |
| evt_pulse | input | NUM_EVT | Per-counter event inputs, one bit per event counter |

## Verification
The properties assume that the strobes, privilege flag, index and data are at known levels at every sampled edge after reset. They also assume that write data is stable through the edge on which it is taken. The counter-step property relies on the cycle counter being reachable only through its own enable and the master-run bit. The bench drives every input on the falling clock edge and holds it across the next rising edge. It never raises the read and write strobes together, and it changes the event inputs only between directed steps. This keeps each property's antecedent cleanly tied to a single access.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_ARM    = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_DISARM = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_USR    = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CYC    = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_EVT0   = 3'd5;

  // Implemented enable bits: event counters at the bottom, cycle counter at cyc.
  function automatic logic [BUS_W-1:0] en_mask_f(int nevt, int cyc);
    logic [BUS_W-1:0] m;
    m = '0;
    for (int i = 0; i < nevt; i++) m[i] = 1'b1;
    m[cyc] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/perf_access_guard.sv
module perf_access_guard
  import perf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_user,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              usr_en,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic              err_q
);
  logic refuse;

  always_comb begin
    refuse = 1'b0;
    if (bus_user && (bus_wr || bus_rd)) begin
      if (!usr_en)                          refuse = 1'b1;
      else if (bus_wr && bus_addr == ADR_USR) refuse = 1'b1;
    end
  end

  assign wr_ok = bus_wr && !refuse;
  assign rd_ok = bus_rd && !refuse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= refuse;
  end
endmodule

// File: rtl/perf_enable_reg.sv
module perf_enable_reg
  import perf_pkg::*;
#(
  parameter logic [BUS_W-1:0] MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_we,
  input  logic             disarm_we,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] en_q
);
  logic [BUS_W-1:0] set_bits;
  logic [BUS_W-1:0] clr_bits;
  logic [BUS_W-1:0] en_d;

  assign set_bits = arm_we    ? wdata : '0;
  assign clr_bits = disarm_we ? wdata : '0;
  // Clearing is applied last, so it dominates a same-cycle set.
  assign en_d     = ((en_q | set_bits) & ~clr_bits) & MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end
endmodule

// File: rtl/perf_counter.sv
module perf_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (inc) cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/perf_enable_ctrl.sv
module perf_enable_ctrl
  import perf_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 3,
  parameter int CYC_BIT = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic               bus_user,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               bus_err,
  input  logic [NUM_EVT-1:0] evt_pulse
);
  localparam int               NUM_CNT = NUM_EVT + 1;
  localparam logic [BUS_W-1:0] EN_MASK = en_mask_f(NUM_EVT, CYC_BIT);

  logic             wr_ok;
  logic             rd_ok;
  logic             gen_q;
  logic             usr_en_q;
  logic [BUS_W-1:0] en_vec;
  logic [BUS_W-1:0] rd_val;
  logic [CNT_W-1:0] cnt_q [NUM_CNT];

  perf_access_guard u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_user (bus_user),
    .bus_addr (bus_addr),
    .usr_en   (usr_en_q),
    .wr_ok    (wr_ok),
    .rd_ok    (rd_ok),
    .err_q    (bus_err)
  );

  perf_enable_reg #(.MASK(EN_MASK)) u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_we    (wr_ok && bus_addr == ADR_ARM),
    .disarm_we (wr_ok && bus_addr == ADR_DISARM),
    .wdata     (bus_wdata),
    .en_q      (en_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q    <= 1'b0;
      usr_en_q <= 1'b0;
    end else if (wr_ok) begin
      if (bus_addr == ADR_CTRL) gen_q    <= bus_wdata[0];
      if (bus_addr == ADR_USR)  usr_en_q <= bus_wdata[0];
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic bump;
    if (g == 0) begin : g_cyc
      assign bump = gen_q && en_vec[CYC_BIT];
    end else begin : g_evt
      assign bump = gen_q && en_vec[g-1] && evt_pulse[g-1];
    end
    perf_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (bump),
      .cnt   (cnt_q[g])
    );
  end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      ADR_CTRL:            rd_val = {{(BUS_W-1){1'b0}}, gen_q};
      ADR_ARM, ADR_DISARM: rd_val = en_vec;
      ADR_USR:             rd_val = {{(BUS_W-1){1'b0}}, usr_en_q};
      ADR_CYC:             rd_val = BUS_W'(cnt_q[0]);
      default: begin
        for (int i = 0; i < NUM_EVT; i++)
          if (int'(bus_addr) == int'(ADR_EVT0) + i) rd_val = BUS_W'(cnt_q[i+1]);
      end
    endcase
  end

  assign bus_rdata = rd_ok ? rd_val : '0;
endmodule

// File: rtl/perf_enable_ctrl_chk.sv
module perf_enable_ctrl_chk
  import perf_pkg::*;
#(
  parameter int               CNT_W   = 32,
  parameter int               CYC_BIT = 31,
  parameter logic [BUS_W-1:0] EN_MASK = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_user,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              bus_err,
  input logic [BUS_W-1:0]  en_vec,
  input logic              gen_q,
  input logic              usr_en_q,
  input logic [CNT_W-1:0]  cyc_cnt
);
  logic den;
  logic arm_ok;
  logic dis_ok;

  assign den    = bus_user && (bus_wr || bus_rd) &&
                  (!usr_en_q || (bus_wr && bus_addr == ADR_USR));
  assign arm_ok = bus_wr && !den && bus_addr == ADR_ARM;
  assign dis_ok = bus_wr && !den && bus_addr == ADR_DISARM;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_STATE: assert (en_vec == '0 && !gen_q && !usr_en_q && cyc_cnt == '0); // R4
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == ADR_ARM || bus_addr == ADR_DISARM)) |-> ((bus_rdata & ~EN_MASK) == '0)); // R1
  AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dis_ok |=> ((en_vec & $past(bus_wdata)) == '0)); // R2
  AST_DISARM_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    dis_ok |=> ((en_vec & ~$past(bus_wdata)) == ($past(en_vec) & ~$past(bus_wdata)))); // R2
  AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    arm_ok |=> ((en_vec & $past(bus_wdata) & EN_MASK) == ($past(bus_wdata) & EN_MASK))); // R5
  AST_ARM_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    arm_ok |=> (($past(en_vec) & ~en_vec) == '0)); // R5
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q |=> $stable(cyc_cnt)); // R6
  AST_EN_RETAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !(arm_ok || dis_ok) |=> $stable(en_vec)); // R7
  AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_q && en_vec[CYC_BIT]) |=> (cyc_cnt == CNT_W'($past(cyc_cnt) + CNT_W'(1)))); // R8
  AST_DENY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    den |=> bus_err); // R9
  AST_DENY_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (den && bus_rd) |-> (bus_rdata == '0)); // R9
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(den)); // R9
  AST_USR_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_user && bus_wr && bus_addr == ADR_USR) |=> $stable(usr_en_q)); // R10
endmodule

bind perf_enable_ctrl perf_enable_ctrl_chk #(
  .CNT_W   (CNT_W),
  .CYC_BIT (CYC_BIT),
  .EN_MASK (EN_MASK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_user  (bus_user),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .en_vec    (en_vec),
  .gen_q     (gen_q),
  .usr_en_q  (usr_en_q),
  .cyc_cnt   (cnt_q[0])
);

// File: tb/tb_perf_enable_ctrl.sv
module tb_perf_enable_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_user = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [2:0]  evt_pulse = 3'b000;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  perf_enable_ctrl #(.CNT_W(8), .NUM_EVT(3), .CYC_BIT(31)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_user  (bus_user),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .evt_pulse (evt_pulse)
  );

  // Entry: {req[3:0], wr, user, addr[2:0], wdata[31:0], exp_rdata[31:0], exp_err}
  localparam int NV = 29;
  localparam logic [73:0] TBL [NV] = '{
    {4'd4,  1'b0, 1'b0, 3'd1, 32'h0,        32'h0,        1'b0}, // R4 arm view zero after reset
    {4'd5,  1'b1, 1'b0, 3'd1, 32'hFFFF_FFFF, 32'h0,       1'b0}, // R5 arm all
    {4'd1,  1'b0, 1'b0, 3'd1, 32'h0,        32'h8000_0007, 1'b0}, // R1 only implemented bits
    {4'd3,  1'b0, 1'b0, 3'd2, 32'h0,        32'h8000_0007, 1'b0}, // R3 disarm view agrees
    {4'd2,  1'b1, 1'b0, 3'd2, 32'h0000_0002, 32'h0,       1'b0}, // R2 disarm event 1
    {4'd2,  1'b0, 1'b0, 3'd1, 32'h0,        32'h8000_0005, 1'b0}, // R2 seen in arm view
    {4'd5,  1'b1, 1'b0, 3'd1, 32'h0,        32'h0,        1'b0}, // R5 zero arm write
    {4'd5,  1'b0, 1'b0, 3'd1, 32'h0,        32'h8000_0005, 1'b0}, // R5 unchanged
    {4'd2,  1'b1, 1'b0, 3'd2, 32'h0,        32'h0,        1'b0}, // R2 zero disarm write
    {4'd3,  1'b0, 1'b0, 3'd2, 32'h0,        32'h8000_0005, 1'b0}, // R3 unchanged
    {4'd2,  1'b1, 1'b0, 3'd2, 32'h8000_0000, 32'h0,       1'b0}, // R2 disarm cycle counter
    {4'd2,  1'b0, 1'b0, 3'd1, 32'h0,        32'h0000_0005, 1'b0}, // R2
    {4'd9,  1'b0, 1'b1, 3'd1, 32'h0,        32'h0,        1'b1}, // R9 user read refused
    {4'd9,  1'b1, 1'b1, 3'd2, 32'h0000_0005, 32'h0,       1'b1}, // R9 user write refused
    {4'd9,  1'b0, 1'b0, 3'd1, 32'h0,        32'h0000_0005, 1'b0}, // R9 no update
    {4'd10, 1'b1, 1'b1, 3'd3, 32'h0000_0001, 32'h0,       1'b1}, // R10 user cannot grant itself
    {4'd10, 1'b0, 1'b0, 3'd3, 32'h0,        32'h0,        1'b0}, // R10
    {4'd10, 1'b1, 1'b0, 3'd3, 32'h0000_0001, 32'h0,       1'b0}, // R10 privileged grant
    {4'd10, 1'b0, 1'b0, 3'd3, 32'h0,        32'h0000_0001, 1'b0}, // R10
    {4'd9,  1'b0, 1'b1, 3'd1, 32'h0,        32'h0000_0005, 1'b0}, // R9 user read allowed
    {4'd9,  1'b1, 1'b1, 3'd1, 32'h0000_0002, 32'h0,       1'b0}, // R9 user arm allowed
    {4'd3,  1'b0, 1'b1, 3'd2, 32'h0,        32'h0000_0007, 1'b0}, // R3
    {4'd10, 1'b1, 1'b1, 3'd3, 32'h0,        32'h0,        1'b1}, // R10 user revoke refused
    {4'd10, 1'b0, 1'b0, 3'd3, 32'h0,        32'h0000_0001, 1'b0}, // R10
    {4'd11, 1'b1, 1'b0, 3'd4, 32'h0000_0123, 32'h0,       1'b0}, // R11 counter write dropped
    {4'd11, 1'b0, 1'b0, 3'd4, 32'h0,        32'h0,        1'b0}, // R11
    {4'd4,  1'b0, 1'b0, 3'd0, 32'h0,        32'h0,        1'b0}, // R4 control zero
    {4'd1,  1'b1, 1'b0, 3'd1, 32'h00FF_0000, 32'h0,       1'b0}, // R1 reserved bits
    {4'd1,  1'b0, 1'b0, 3'd1, 32'h0,        32'h0000_0007, 1'b0}  // R1 reserved ignored
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Called at a falling edge; consumes one rising edge.
  task automatic wr_t(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_user = 1'b0; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_wdata = 32'h0;
    @(negedge clk);
  endtask

  // Called at a falling edge; consumes no rising edge.
  task automatic rd_t(input logic [2:0] a, input logic [31:0] exp, input string req);
    bus_rd = 1'b1; bus_user = 1'b0; bus_addr = a;
    #1 check(req, bus_rdata, exp);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [73:0] v;
      string tag;
      v = TBL[i];
      tag = $sformatf("R%0d", v[73:70]);
      bus_wr = v[69]; bus_rd = !v[69]; bus_user = v[68];
      bus_addr = v[67:65]; bus_wdata = v[64:33];
      #1;
      if (!v[69]) check(tag, bus_rdata, v[32:1]);
      @(posedge clk); #1;
      check({tag, " err"}, {31'h0, bus_err}, {31'h0, v[0]});
      bus_wr = 1'b0; bus_rd = 1'b0; bus_user = 1'b0; bus_wdata = 32'h0;
      @(negedge clk);
    end

    // R6: enables 0x7 stored, master-run off, events active: nothing counts
    evt_pulse = 3'b111;
    repeat (5) @(negedge clk);
    rd_t(3'd4, 32'd0, "R6");
    rd_t(3'd5, 32'd0, "R6");
    rd_t(3'd7, 32'd0, "R6");
    // R7: enables still writable while halted
    wr_t(3'd1, 32'h8000_0000);
    rd_t(3'd1, 32'h8000_0007, "R7");
    wr_t(3'd2, 32'h0000_0004);
    rd_t(3'd2, 32'h8000_0003, "R7");
    rd_t(3'd4, 32'd0, "R6");
    // R6/R8: master-run on
    wr_t(3'd0, 32'h1);
    rd_t(3'd0, 32'h1, "R6");
    repeat (10) @(negedge clk);
    rd_t(3'd4, 32'd10, "R8");
    rd_t(3'd5, 32'd10, "R8");
    rd_t(3'd6, 32'd10, "R8");
    rd_t(3'd7, 32'd0,  "R8");
    evt_pulse = 3'b001;
    repeat (3) @(negedge clk);
    rd_t(3'd4, 32'd13, "R8");
    rd_t(3'd5, 32'd13, "R8");
    rd_t(3'd6, 32'd10, "R8");
    // Halt: the write edge still counts, later edges do not
    wr_t(3'd0, 32'h0);
    repeat (4) @(negedge clk);
    rd_t(3'd4, 32'd14, "R6");
    rd_t(3'd5, 32'd14, "R6");
    // R8 wrap at 8 bits
    wr_t(3'd0, 32'h1);
    repeat (250) @(negedge clk);
    rd_t(3'd4, 32'd8,  "R8");
    rd_t(3'd5, 32'd8,  "R8");
    rd_t(3'd6, 32'd10, "R8");

    // R4: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_t(3'd0, 32'd0, "R4");
    rd_t(3'd1, 32'd0, "R4");
    rd_t(3'd3, 32'd0, "R4");
    rd_t(3'd4, 32'd0, "R4");
    rd_t(3'd5, 32'd0, "R4");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule